// File: doc/BRIEF.md
# Sector Erase Collection Timer

This block sits behind a flash command decoder and gathers sector erase requests into a set before the erase engine is started. Each decoded sector erase request names one of the sectors by number; the block sets the matching bit of a sector mask and opens a quiet window of a fixed number of clock cycles. Each further request received while the window is open adds its sector and restarts the window, so a host may queue any combination of sectors, in any order, by issuing requests back to back.

When the window runs out with no further request, the block raises a one-cycle erase start pulse while presenting the collected mask, then clears the mask. If the decoder reports any other command while the window is open, the pending set is thrown away: the block raises a one-cycle cancel pulse that returns the device to read mode and no erase is started. The window length is a parameter in clock cycles, chosen by the integrator to span 100 µs at the system clock.

Top module: `sector_gather_timer`

## Requirements
- R1: After reset the mask is all zero and collecting, erase_start and cancel_read are low; with no window open the mask stays zero.
- R2: A request (req_valid high, foreign_cmd low) sampled with no window open sets mask bit N for sector number N and raises collecting from the next cycle.
- R3: A request sampled while collecting sets its sector's bit, keeps the other bits, and restarts the window from zero.
- R4: If the last request was sampled at clock edge E, erase_start is high for exactly one cycle after edge E+WINDOW_CYCLES, collecting drops at that edge, and the mask during the pulse holds every collected sector.
- R5: foreign_cmd sampled while collecting raises cancel_read for one cycle after that edge, drops collecting, and no erase_start follows for that set.
- R6: Sectors may be requested in any order and any subset of the NUM_SECTORS sectors, up to all of them, ends in one erase_start with all requested bits set.
- R7: A repeated request for a sector already in the mask leaves the mask unchanged but still restarts the window.
- R8: In the cycle after an erase_start or cancel_read pulse the mask is zero and collecting is low, unless a request was sampled during the pulse.
- R9: A request and foreign_cmd sampled together while collecting resolve as a cancel, and the request's sector is not added to the mask.
- R10: foreign_cmd sampled while no window is open produces no cancel_read pulse and opens no window, and a request sampled together with it is dropped.
- R11: A request sampled during an erase_start or cancel_read pulse opens a new window whose mask holds only that sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle sector erase request from the decoder |
| req_sector | input | SEC_W | Sector number carried by the request |
| foreign_cmd | input | 1 | One-cycle indication of any command other than sector erase |
| mask_o | output | NUM_SECTORS | Collected sector set, bit N for sector N |
| erase_start | output | 1 | One-cycle pulse launching erase of the set in mask_o |
| cancel_read | output | 1 | One-cycle pulse discarding the set and returning to read mode |
| collecting | output | 1 | High while a quiet window is open |

## Verification
The assertions take for granted that req_sector is below NUM_SECTORS whenever req_valid is high and that the inputs are synchronous to clk, so every sampled request maps to exactly one mask bit. The bench drives req_valid and foreign_cmd for single cycles on the falling edge and only with legal sector numbers, including the deliberate overlaps of a request with a foreign command and a request in the pulse cycle. The checker keeps its own count of quiet cycles since the last accepted request and relates the start pulse to that count rather than to the design's timer.

// File: rtl/sgt_pkg.sv
package sgt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_LAUNCH  = 2'd2,
    ST_CANCEL  = 2'd3
  } sgt_state_e;

  // True on the last cycle of a window of length 'window'.
  function automatic logic window_done(input logic [31:0] count,
                                       input logic [31:0] window);
    return (count + 32'd1) == window;
  endfunction

  // A request is taken only when no foreign command competes with it.
  function automatic logic request_ok(input logic req, input logic foreign);
    return req && !foreign;
  endfunction

endpackage

// File: rtl/sgt_sector_decode.sv
module sgt_sector_decode #(
  parameter int NUM_SECTORS = 8,
  parameter int SEC_W       = $clog2(NUM_SECTORS)
) (
  input  logic [SEC_W-1:0]       sector,
  output logic [NUM_SECTORS-1:0] bits
);
  for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_bit
    assign bits[i] = (sector == SEC_W'(i));
  end
endmodule

// File: rtl/sgt_window_timer.sv
module sgt_window_timer #(
  parameter int WINDOW_CYCLES = 5000,
  parameter int CNT_W         = $clog2(WINDOW_CYCLES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expired
);
  import sgt_pkg::*;

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (restart)  count_q <= '0;
    else if (run)      count_q <= count_q + CNT_W'(1);
    else               count_q <= '0;
  end

  assign expired = run && window_done(32'(count_q), 32'(WINDOW_CYCLES));
endmodule

// File: rtl/sgt_mask_accum.sv
module sgt_mask_accum #(
  parameter int NUM_SECTORS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   add_en,
  input  logic                   load_en,
  input  logic                   clear,
  input  logic [NUM_SECTORS-1:0] new_bits,
  output logic [NUM_SECTORS-1:0] mask
);
  for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_cell
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bit_q <= 1'b0;
      else if (load_en) bit_q <= new_bits[i];
      else if (add_en)  bit_q <= bit_q | new_bits[i];
      else if (clear)   bit_q <= 1'b0;
    end
    assign mask[i] = bit_q;
  end
endmodule

// File: rtl/sgt_collect_fsm.sv
module sgt_collect_fsm (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_ok,
  input  logic              foreign,
  input  logic              expired,
  output sgt_pkg::sgt_state_e state,
  output logic              mask_add,
  output logic              mask_load,
  output logic              mask_clear
);
  import sgt_pkg::*;

  sgt_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    mask_add   = 1'b0;
    mask_load  = 1'b0;
    mask_clear = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_ok) begin
          state_d   = ST_COLLECT;
          mask_load = 1'b1;
        end
      end
      ST_COLLECT: begin
        if (foreign)       state_d = ST_CANCEL;
        else if (req_ok)   mask_add = 1'b1;
        else if (expired)  state_d = ST_LAUNCH;
      end
      ST_LAUNCH, ST_CANCEL: begin
        if (req_ok) begin
          state_d   = ST_COLLECT;
          mask_load = 1'b1;
        end else begin
          state_d    = ST_IDLE;
          mask_clear = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/sector_gather_timer.sv
module sector_gather_timer #(
  parameter int NUM_SECTORS   = 8,
  parameter int WINDOW_CYCLES = 5000,
  parameter int SEC_W         = $clog2(NUM_SECTORS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [SEC_W-1:0]       req_sector,
  input  logic                   foreign_cmd,
  output logic [NUM_SECTORS-1:0] mask_o,
  output logic                   erase_start,
  output logic                   cancel_read,
  output logic                   collecting
);
  import sgt_pkg::*;

  localparam int CNT_W = $clog2(WINDOW_CYCLES);

  // Named internal events.
  logic               ev_accept;
  logic               ev_expire;
  logic               ev_add;
  logic               ev_load;
  logic               ev_clear;
  logic               ev_restart;
  logic [NUM_SECTORS-1:0] req_bits;
  sgt_state_e         state;

  assign ev_accept  = request_ok(req_valid, foreign_cmd);
  assign ev_restart = ev_add | ev_load;

  sgt_sector_decode #(.NUM_SECTORS(NUM_SECTORS), .SEC_W(SEC_W)) u_dec (
    .sector (req_sector),
    .bits   (req_bits)
  );

  sgt_collect_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ok     (ev_accept),
    .foreign    (foreign_cmd),
    .expired    (ev_expire),
    .state      (state),
    .mask_add   (ev_add),
    .mask_load  (ev_load),
    .mask_clear (ev_clear)
  );

  sgt_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES), .CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (ev_restart),
    .run     (state == ST_COLLECT),
    .expired (ev_expire)
  );

  sgt_mask_accum #(.NUM_SECTORS(NUM_SECTORS)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .add_en   (ev_add),
    .load_en  (ev_load),
    .clear    (ev_clear),
    .new_bits (req_bits),
    .mask     (mask_o)
  );

  assign collecting  = (state == ST_COLLECT);
  assign erase_start = (state == ST_LAUNCH);
  assign cancel_read = (state == ST_CANCEL);
endmodule

// File: rtl/sector_gather_checker.sv
module sector_gather_checker #(
  parameter int NUM_SECTORS   = 8,
  parameter int WINDOW_CYCLES = 5000,
  parameter int SEC_W         = $clog2(NUM_SECTORS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic [SEC_W-1:0]       req_sector,
  input logic                   foreign_cmd,
  input logic [NUM_SECTORS-1:0] mask_o,
  input logic                   erase_start,
  input logic                   cancel_read,
  input logic                   collecting
);
  logic [31:0] quiet_cnt;
  logic        taken;
  logic        window_shut;

  assign taken       = req_valid && !foreign_cmd;
  assign window_shut = !collecting && !erase_start && !cancel_read;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          quiet_cnt <= '0;
    else if (taken)      quiet_cnt <= '0;
    else if (collecting) quiet_cnt <= quiet_cnt + 32'd1;
  end

  a_r1_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    window_shut |-> mask_o == '0);

  a_r2_first_opens: assert property (@(posedge clk) disable iff (!rst_n)
    window_shut && taken |=> collecting && $countones(mask_o) == 1
                              && mask_o[$past(req_sector)]);

  a_r3_adds_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    collecting && taken |=> collecting && mask_o[$past(req_sector)]
                            && (($past(mask_o) & ~mask_o) == '0));

  a_r4_start_on_window: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> quiet_cnt == WINDOW_CYCLES);

  a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);

  a_r5_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    collecting && foreign_cmd |=> cancel_read && !erase_start && !collecting
                                  && mask_o == $past(mask_o));

  a_r8_clear_after: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_start || cancel_read) && !taken |=> mask_o == '0 && !collecting);

  a_r10_foreign_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !collecting && foreign_cmd |=> !cancel_read && !collecting);

  a_r11_reopen: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_start || cancel_read) && taken |=> collecting
        && $countones(mask_o) == 1 && mask_o[$past(req_sector)]);

  a_r4_pulses_apart: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({erase_start, cancel_read, collecting}) <= 1);
endmodule

bind sector_gather_timer sector_gather_checker #(
  .NUM_SECTORS   (NUM_SECTORS),
  .WINDOW_CYCLES (WINDOW_CYCLES),
  .SEC_W         (SEC_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_sector  (req_sector),
  .foreign_cmd (foreign_cmd),
  .mask_o      (mask_o),
  .erase_start (erase_start),
  .cancel_read (cancel_read),
  .collecting  (collecting)
);

// File: tb/sector_gather_timer_bench.sv
`timescale 1ns/1ps
module sector_gather_timer_bench;
  localparam int NS = 8;
  localparam int W  = 12;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [SW-1:0] req_sector = '0;
  logic          foreign_cmd = 1'b0;
  logic [NS-1:0] mask_o;
  logic          erase_start, cancel_read, collecting;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  sector_gather_timer #(.NUM_SECTORS(NS), .WINDOW_CYCLES(W)) u_sector_gather_timer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sector(req_sector),
    .foreign_cmd(foreign_cmd), .mask_o(mask_o), .erase_start(erase_start),
    .cancel_read(cancel_read), .collecting(collecting)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_req(input int s, input logic with_foreign);
    req_valid = 1'b1; req_sector = SW'(s); foreign_cmd = with_foreign;
    step(1);
    req_valid = 1'b0; foreign_cmd = 1'b0;
  endtask

  task automatic send_foreign();
    foreign_cmd = 1'b1;
    step(1);
    foreign_cmd = 1'b0;
  endtask

  // Expect the window to close W edges after the last request edge.
  task automatic expect_launch(input string tag, input logic [NS-1:0] exp_mask);
    step(W - 1);
    chk({tag, " no start before window"}, {31'd0, erase_start}, 0);
    chk({tag, " still collecting"}, {31'd0, collecting}, 1);
    step(1);
    chk({tag, " start pulse"}, {31'd0, erase_start}, 1);
    chk({tag, " collecting low in pulse"}, {31'd0, collecting}, 0);
    chk({tag, " mask in pulse"}, 32'(mask_o), 32'(exp_mask));
  endtask

  task automatic t_reset();
    chk("R1 reset mask", 32'(mask_o), 0);
    chk("R1 reset flags", {29'd0, erase_start, cancel_read, collecting}, 0);
  endtask

  task automatic t_single();
    send_req(5, 1'b0);
    chk("R2 first bit", 32'(mask_o), 32'h20);
    chk("R2 collecting", {31'd0, collecting}, 1);
    expect_launch("R4 single", 8'h20);
    step(1);
    chk("R8 mask cleared after start", 32'(mask_o), 0);
    chk("R8 flags after start", {29'd0, erase_start, cancel_read, collecting}, 0);
  endtask

  task automatic t_retrigger();
    send_req(0, 1'b0);
    step(5);
    send_req(7, 1'b0);
    chk("R3 added bit", 32'(mask_o), 32'h81);
    expect_launch("R3 restart", 8'h81);
    step(1);
  endtask

  task automatic t_repeat();
    send_req(3, 1'b0);
    step(4);
    send_req(3, 1'b0);
    chk("R7 mask unchanged", 32'(mask_o), 32'h08);
    expect_launch("R7 repeat restarts", 8'h08);
    step(1);
  endtask

  task automatic t_all_order();
    int order [8] = '{6, 1, 4, 0, 7, 2, 5, 3};
    foreach (order[k]) begin
      send_req(order[k], 1'b0);
      if (k != 7) step(2);
    end
    expect_launch("R6 all sectors", 8'hFF);
    step(1);
    send_req(2, 1'b0);
    step(1);
    send_req(6, 1'b0);
    expect_launch("R6 subset", 8'h44);
    step(1);
  endtask

  task automatic t_cancel();
    send_req(2, 1'b0);
    step(3);
    send_foreign();
    chk("R5 cancel pulse", {31'd0, cancel_read}, 1);
    chk("R5 no start", {31'd0, erase_start}, 0);
    chk("R5 collecting dropped", {31'd0, collecting}, 0);
    step(1);
    chk("R8 mask cleared after cancel", 32'(mask_o), 0);
    for (int i = 0; i < W + 2; i++) begin
      step(1);
      chk("R5 no later start", {31'd0, erase_start}, 0);
    end
  endtask

  task automatic t_coincident();
    send_req(1, 1'b0);
    step(2);
    send_req(4, 1'b1);
    chk("R9 cancel wins", {31'd0, cancel_read}, 1);
    chk("R9 sector not added", 32'(mask_o), 32'h02);
    step(1);
  endtask

  task automatic t_foreign_idle();
    send_foreign();
    chk("R10 no cancel when idle", {29'd0, erase_start, cancel_read, collecting}, 0);
    send_req(6, 1'b1);
    chk("R10 coincident request dropped", {29'd0, erase_start, cancel_read, collecting}, 0);
    chk("R10 mask untouched", 32'(mask_o), 0);
  endtask

  task automatic t_reopen();
    send_req(4, 1'b0);
    step(W);
    chk("R11 in start pulse", {31'd0, erase_start}, 1);
    send_req(1, 1'b0);
    chk("R11 new window after start", {31'd0, collecting}, 1);
    chk("R11 mask holds only new sector", 32'(mask_o), 32'h02);
    step(1);
    send_foreign();
    chk("R11 in cancel pulse", {31'd0, cancel_read}, 1);
    send_req(7, 1'b0);
    chk("R11 mask after cancel reopen", 32'(mask_o), 32'h80);
    expect_launch("R11 reopened launch", 8'h80);
    step(1);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_single();
    t_retrigger();
    t_repeat();
    t_all_order();
    t_cancel();
    t_coincident();
    t_foreign_idle();
    t_reopen();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule